// File: doc/BRIEF.md
# Round-Robin Iterative Crossbar Matcher

This block chooses which inputs of an N-by-N cell switch may send to which outputs in the next transfer slot. Every input keeps a separate queue per output and reports, as one bit per output, whether each of those queues is non-empty. On a start pulse the block captures that request matrix and builds a conflict-free set of input-output pairs.

Matching runs as a number of iterations. Each iteration has a grant step and an accept step. In the grant step every output offers itself to one requesting input, chosen in round-robin order from that output's pointer. In the accept step every input that received offers takes one of them, chosen in round-robin order from that input's own pointer. Pointers move only on acceptances in the first iteration. This is what spreads service fairly under sustained load. Later iterations fill in pairs among the ports that are still free.

After a fixed number of cycles a one-cycle done pulse marks the result. The result is a one-hot row per input, and it stays on the output until the next start.

Top module: `rr_xbar_matcher`

## Requirements
- R1: With the block idle, a start pulse captures `req`, where bit `i*N+o` set means input i holds a cell for output o. Later changes on `req` do not affect that matching.
- R2: In each grant step, every output that is still unmatched picks the first input that is requesting it and still unmatched. The search begins at the output's grant pointer and proceeds upward with wraparound.
- R3: In each accept step, every unmatched input that received offers takes the first offering output. The search begins at the input's accept pointer and proceeds upward with wraparound.
- R4: When input i accepts output o in the first iteration, the accept pointer of input i becomes (o+1) mod N and the grant pointer of output o becomes (i+1) mod N. An output whose offer was declined keeps its pointer.
- R5: Iterations after the first involve only ports left unmatched, add to the existing pairs, and leave all pointers unchanged. There are ITER iterations in total.
- R6: `done` is high for exactly one cycle, and it first reads high 2*ITER clock edges after the edge that sampled `start`. From that point `match` holds the result until the next accepted start. Bit `i*N+o` of `match` pairs input i with output o.
- R7: The result never gives one output to two inputs or one input to two outputs, and it never contains a pair whose request bit was clear.
- R8: A start pulse that arrives while a matching is in progress is ignored. It produces no extra done pulse and does not change the result.
- R9: After reset all pointers are 0, `done` is low and `match` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a matching with the current `req` |
| req | input | N*N | Request matrix, bit i*N+o = input i wants output o |
| done | output | 1 | One-cycle pulse: `match` is valid |
| match | output | N*N | Result matrix, at most one bit per row and per column |

## Verification
The bench builds the block with its defaults, N=4 and ITER=3. With these values, full-load request patterns run out of iterations before they reach a maximal matching, so the third iteration's leftovers can be seen. A single hot column puts four inputs in competition for one output and shows the grant pointer rotating over successive matchings. Because a software model carries the pointer state from one matching to the next, every result in a long run of pseudo-random patterns also depends on how the pointers were updated earlier.

// File: rtl/rr_xbar_matcher.sv
module rr_xbar_matcher #(
  parameter int N    = 4,
  parameter int ITER = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*N-1:0] req,
  output logic           done,
  output logic [N*N-1:0] match
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;

  logic                   busy_q, ph_q, done_q;
  logic [IW-1:0]          it_q;
  logic [N*N-1:0]         req_q, match_q;
  logic [N-1:0][N-1:0]    gnt_q, gnt_d, acc_d, colm;
  logic [N-1:0][PW-1:0]   gptr_q, aptr_q;
  logic [N-1:0]           in_free, out_free;

  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] v, input logic [PW-1:0] p);
    logic [N-1:0] r;
    r = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(p) + k) % N;
      if (v[idx] && r == '0) r[idx] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] nxt(input int x);
    return PW'((x + 1) % N);
  endfunction

  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++) colm[o][i] = match_q[i*N+o];
    for (int i = 0; i < N; i++) in_free[i] = ~|match_q[i*N +: N];
    for (int o = 0; o < N; o++) out_free[o] = ~|colm[o];
    for (int o = 0; o < N; o++) begin
      logic [N-1:0] cand;
      for (int i = 0; i < N; i++) cand[i] = req_q[i*N+o] & in_free[i] & out_free[o];
      gnt_d[o] = rr_pick(cand, gptr_q[o]);
    end
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] offers;
      for (int o = 0; o < N; o++) offers[o] = gnt_q[o][i] & in_free[i];
      acc_d[i] = rr_pick(offers, aptr_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ph_q <= 1'b0; done_q <= 1'b0; it_q <= '0;
      req_q <= '0; match_q <= '0; gnt_q <= '0;
      gptr_q <= '0; aptr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1; ph_q <= 1'b0; it_q <= '0;
          req_q <= req; match_q <= '0;
        end
      end else if (!ph_q) begin
        gnt_q <= gnt_d;
        ph_q  <= 1'b1;
      end else begin
        ph_q <= 1'b0;
        for (int i = 0; i < N; i++) begin
          if (acc_d[i] != '0) begin
            match_q[i*N +: N] <= acc_d[i];
            if (it_q == '0) begin
              for (int o = 0; o < N; o++) begin
                if (acc_d[i][o]) begin
                  aptr_q[i] <= nxt(o);
                  gptr_q[o] <= nxt(i);
                end
              end
            end
          end
        end
        if (int'(it_q) == ITER - 1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          it_q <= it_q + 1'b1;
        end
      end
    end
  end

  assign done  = done_q;
  assign match = match_q;

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_from_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));
  p_no_unrequested_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((match_q & ~req_q) == '0));
  p_ptr_frozen_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && it_q != '0) |=> ($stable(gptr_q) && $stable(aptr_q)));
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(req_q));
  p_start_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start) |=> (busy_q && match_q == '0));

  for (genvar o = 0; o < N; o++) begin : g_col
    p_one_input_per_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(colm[o]));
  end
endmodule

// File: tb/rr_xbar_matcher_tb.sv
module rr_xbar_matcher_tb;
  localparam int N     = 4;
  localparam int ITER  = 3;
  localparam int NN    = N * N;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NN-1:0] req = '0;
  logic          done;
  logic [NN-1:0] match;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  int mg[N], ma[N];

  logic [NN-1:0] q_m[$];
  int            q_c[$];
  string         q_t[$];

  rr_xbar_matcher #(.N(N), .ITER(ITER)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .done(done), .match(match));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [NN-1:0] r, output logic [NN-1:0] m);
    bit in_m[N], out_m[N];
    int g[N];
    m = '0;
    for (int k = 0; k < N; k++) begin in_m[k] = 0; out_m[k] = 0; end
    for (int it = 0; it < ITER; it++) begin
      for (int o = 0; o < N; o++) begin
        g[o] = -1;
        if (!out_m[o])
          for (int k = 0; k < N; k++) begin
            int i;
            i = (mg[o] + k) % N;
            if (g[o] < 0 && r[i*N+o] && !in_m[i]) g[o] = i;
          end
      end
      for (int i = 0; i < N; i++) begin
        bit took;
        took = 0;
        if (!in_m[i])
          for (int k = 0; k < N; k++) begin
            int o;
            o = (ma[i] + k) % N;
            if (!took && g[o] == i) begin
              took = 1;
              m[i*N+o] = 1'b1;
              in_m[i] = 1; out_m[o] = 1;
              if (it == 0) begin
                ma[i] = (o + 1) % N;
                mg[o] = (i + 1) % N;
              end
            end
          end
      end
    end
  endtask

  task automatic run(input logic [NN-1:0] r, input string tag);
    logic [NN-1:0] m;
    model(r, m);
    @(negedge clk);
    req = r; start = 1'b1;
    q_m.push_back(m); q_c.push_back(cyc + 1 + 2*ITER); q_t.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    req = ~r;
    repeat (2*ITER + 1) @(negedge clk);
  endtask

  task automatic run_with_busy_start(input logic [NN-1:0] r);
    logic [NN-1:0] m;
    model(r, m);
    @(negedge clk);
    req = r; start = 1'b1;
    q_m.push_back(m); q_c.push_back(cyc + 1 + 2*ITER); q_t.push_back("R8 R1");
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    req = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2*ITER + 2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_m.size() == 0) begin
        check(1'b0, "R8 R6 unexpected done", match, '0);
      end else begin
        logic [NN-1:0] em;
        int ec;
        string t;
        em = q_m.pop_front(); ec = q_c.pop_front(); t = q_t.pop_front();
        check(match === em, {t, " R2 R3 R4 R5 R7 match"}, match, em);
        check(cyc == ec, {t, " R6 latency"}, NN'(cyc), NN'(ec));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NN-1:0] lf;
    for (int k = 0; k < N; k++) begin mg[k] = 0; ma[k] = 0; end
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R9 done after reset", NN'(done), '0);
    check(match === '0, "R9 match after reset", match, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && match === '0, "R9 idle after release", match, '0);

    run('0, "R7 empty");
    run('1, "R4 full load a");
    run('1, "R4 full load b");
    run('1, "R5 full load c");
    run(16'h8421, "R2 diagonal");
    run(16'h4444, "R2 hot column");
    run(16'h4444, "R4 hot column rotate");
    run(16'h4444, "R4 hot column rotate2");
    run(16'h000F, "R3 one input all outputs");
    run(16'h000F, "R3 one input rotate");
    run(16'h1248, "R7 permutation");
    run(16'h0033, "R5 two by two");
    run_with_busy_start(16'h0181);
    lf = 16'hACE1;
    for (int n = 0; n < 12; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run(lf, "R1 pseudo random");
    end
    repeat (4) @(negedge clk);
    check(q_m.size() == 0, "R6 all results delivered", NN'(q_m.size()), '0);
    finish_run();
  end
endmodule